// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block turns per-device "ready" and "interrupt enable" flags into one interrupt request for a processor. Each device owns a 16-bit status word. The ready flag in that word comes live from the device. The enable flag is held in a register that software can write. Each device also has a fixed urgency level from 0 to 7, set by a parameter, and 7 is the most urgent.

A device is pending when its ready and enable flags are both set. A priority encoder finds the most urgent pending device. When two pending devices have the same level, the lower-numbered device wins. The winner's level is then compared with the level of the code the processor is running. The request is raised only when the device's level is strictly greater.

The processor looks at the request once per instruction, between the store phase and the next fetch. It marks that point with a boundary strobe. The request, the winner's level and an 8-bit vector number are registered outputs, and they are refreshed only on clock edges where the strobe is high. Pushing state onto a stack and fetching through the vector are left to the processor.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and for two clock edges after it is released, every enable flag is 0 and `irq`, `irq_level` and `irq_vector` are 0.
- R2: A write with `wr_en` high and `wr_sel` = k stores `wr_data[14]` as the enable flag of device k from the next edge on. All other bits of `wr_data` are ignored, and writes to other devices leave device k unchanged.
- R3: `rd_data` is combinational for device `rd_sel`. Bit 15 is that device's live `dev_ready` input, bit 14 is its enable flag, and bits 13..0 are 0.
- R4: A device takes part in arbitration only when its ready bit and its enable bit are both 1.
- R5: Among the devices taking part, the one with the highest level is chosen. Levels are 0..7 and 7 is the most urgent. The default levels for devices 0..3 are 4, 4, 6, 1.
- R6: When several devices share the highest level, the lowest-numbered one is chosen.
- R7: The request is raised only if the chosen level is strictly greater than `cur_pl`. An equal or lower level gives no request.
- R8: `irq`, `irq_level` and `irq_vector` change only at a rising clock edge where `fetch_bnd` is 1. At every other edge they hold their values.
- R9: When `irq` is 1, `irq_level` is the chosen device's level and `irq_vector` is 0x80 plus the device index. When `irq` is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ready | input | 4 | Live ready flag of each device |
| wr_en | input | 1 | Status register write strobe |
| wr_sel | input | 2 | Device selected for the write |
| wr_data | input | 16 | Write data; only bit 14 is used |
| rd_sel | input | 2 | Device selected for the read |
| rd_data | output | 16 | Status word of the selected device |
| cur_pl | input | 3 | Priority level of the running code |
| fetch_bnd | input | 1 | Instruction boundary strobe |
| irq | output | 1 | Registered interrupt request |
| irq_level | output | 3 | Level of the granted device |
| irq_vector | output | 8 | Vector number of the granted device |

## Verification
The request, level and vector appear one edge after a boundary strobe: they reflect the inputs present at that edge, including enable flags as they stood before any write made on the same edge. A written enable flag shows on `rd_data` after one edge, while the ready bit shows on `rd_data` in the same cycle. Stimulus is driven on falling edges, and the checks sample on the following falling edge, after exactly one rising edge. The reference model counts the two edges of reset synchronisation before it accepts stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int SR_W     = 16;
  localparam int RDY_BIT  = 15;
  localparam int IE_BIT   = 14;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [SR_W-1:0]  sreg_t;
endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_pkg::*;
#(
  parameter int NDEV  = 4,
  parameter int IDX_W = $clog2(NDEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NDEV-1:0]  dev_ready,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_sel,
  input  sreg_t            wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output sreg_t            rd_data,
  output logic [NDEV-1:0]  req
);
  logic [NDEV-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d[wr_sel] = wr_data[IE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[RDY_BIT] = dev_ready[rd_sel];
    rd_data[IE_BIT]  = en_q[rd_sel];
  end

  assign req = dev_ready & en_q;

  // R2: the written bit 14 lands in the selected enable flag
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q[$past(wr_sel)] == $past(wr_data[IE_BIT]));

  // R2: with no write, enables hold
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_pkg::*;
#(
  parameter int                    NDEV    = 4,
  parameter int                    IDX_W   = $clog2(NDEV),
  parameter logic [NDEV*LVL_W-1:0] DEV_LVL = '0
) (
  input  logic [NDEV-1:0]  req,
  output logic             found,
  output lvl_t             best_lvl,
  output logic [IDX_W-1:0] best_idx
);
  lvl_t lvl_of [NDEV];

  generate
    for (genvar g = 0; g < NDEV; g++) begin : g_lvl
      assign lvl_of[g] = DEV_LVL[g*LVL_W +: LVL_W];
    end
  endgenerate

  // Scan from the top index down; ">=" lets a lower index take a tie (R5, R6)
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = NDEV-1; i >= 0; i--) begin
      if (req[i] && (!found || lvl_of[i] >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_of[i];
        best_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_pkg::*;
#(
  parameter int   IDX_W    = 2,
  parameter vec_t VEC_BASE = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_bnd,
  input  logic             found,
  input  lvl_t             best_lvl,
  input  logic [IDX_W-1:0] best_idx,
  input  lvl_t             cur_pl,
  output logic             irq,
  output lvl_t             irq_level,
  output vec_t             irq_vector
);
  logic irq_d;
  lvl_t lvl_d;
  vec_t vec_d;

  always_comb begin
    irq_d = irq;
    lvl_d = irq_level;
    vec_d = irq_vector;
    if (fetch_bnd) begin
      irq_d = found && (best_lvl > cur_pl);
      lvl_d = irq_d ? best_lvl : '0;
      vec_d = irq_d ? (VEC_BASE + VEC_W'(best_idx)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq        <= irq_d;
      irq_level  <= lvl_d;
      irq_vector <= vec_d;
    end
  end

  // R8: outputs frozen without a boundary strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_bnd |=> $stable(irq) && $stable(irq_level) && $stable(irq_vector));

  // R7: a candidate not strictly above the running level never raises irq
  p_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_bnd && !(found && best_lvl > cur_pl) |=> !irq);

  // R9: idle outputs read zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_level == '0 && irq_vector == '0);

  // R4: nothing pending at a boundary means no request afterwards
  p_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_bnd && !found |=> !irq);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                    NDEV     = 4,
  parameter logic [NDEV*LVL_W-1:0] DEV_LVL  = {3'd1, 3'd6, 3'd4, 3'd4},
  parameter logic [VEC_W-1:0]      VEC_BASE = 8'h80,
  localparam int                   IDX_W    = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDEV-1:0]   dev_ready,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [SR_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [SR_W-1:0]   rd_data,
  input  logic [LVL_W-1:0]  cur_pl,
  input  logic              fetch_bnd,
  output logic              irq,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [NDEV-1:0] req;
  logic            found;
  lvl_t            best_lvl;
  logic [IDX_W-1:0] best_idx;

  // Asynchronous assert, synchronous release (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_status_regs #(.NDEV(NDEV), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .dev_ready(dev_ready),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req(req)
  );

  irq_prio_select #(.NDEV(NDEV), .IDX_W(IDX_W), .DEV_LVL(DEV_LVL)) u_sel (
    .req(req), .found(found), .best_lvl(best_lvl), .best_idx(best_idx)
  );

  irq_out_stage #(.IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_out (
    .clk(clk), .rst_n(rst_int_n), .fetch_bnd(fetch_bnd),
    .found(found), .best_lvl(best_lvl), .best_idx(best_idx),
    .cur_pl(cur_pl), .irq(irq), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  // R1: outputs are quiet while internal reset holds
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> !irq && irq_level == '0 && irq_vector == '0);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  dev_ready;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic [2:0]  cur_pl;
  logic        fetch_bnd;
  logic        irq;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state
  int m_lv [4] = '{4, 4, 6, 1};
  bit m_en [4];
  bit m_irq;
  int m_lvl, m_vec, m_sync;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cur_pl(cur_pl), .fetch_bnd(fetch_bnd), .irq(irq),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0;
      foreach (m_en[i]) m_en[i] = 0;
      m_irq = 0; m_lvl = 0; m_vec = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      if (fetch_bnd) begin
        int bl, bi;
        bl = -1; bi = -1;
        for (int i = 0; i < 4; i++)
          if (dev_ready[i] && m_en[i] && m_lv[i] > bl) begin bl = m_lv[i]; bi = i; end
        if (bi >= 0 && bl > int'(cur_pl)) begin
          m_irq = 1; m_lvl = bl; m_vec = 'h80 + bi;
        end else begin
          m_irq = 0; m_lvl = 0; m_vec = 0;
        end
      end
      if (wr_en) m_en[wr_sel] = wr_data[14];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R8 irq vs model", irq, m_irq);
    chk("R9 level vs model", irq_level, m_lvl);
    chk("R9 vector vs model", irq_vector, m_vec);
    chk("R3 rd_data vs model", rd_data, {dev_ready[rd_sel], m_en[rd_sel], 14'b0});
  endtask

  task automatic set_en(input int d, input bit v);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(d); wr_data = v ? 16'hFFFF : 16'hBFFF;
    @(negedge clk);
    wr_en = 0; wr_data = 16'h0;
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; dev_ready = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    rd_sel = 0; cur_pl = 0; fetch_bnd = 1;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq, 0);
    chk("R1 vector in reset", irq_vector, 0);
    rst_n = 1;
    repeat (3) tick();
    for (int d = 0; d < 4; d++) begin
      rd_sel = 2'(d); #1;
      chk("R1 enable clear after reset", rd_data, 0);
    end

    // R2/R3: write all ones, only bit 14 kept
    set_en(0, 1);
    rd_sel = 0; #1;
    chk("R2 only enable bit stored", rd_data, 16'h4000);
    dev_ready[0] = 1; #1;
    chk("R3 ready bit live", rd_data, 16'hC000);
    tick();
    chk("R4 dev0 requests", irq, 1);
    chk("R9 dev0 vector", irq_vector, 8'h80);
    chk("R9 dev0 level", irq_level, 4);

    // R6: tie between dev0 and dev1
    dev_ready[1] = 1;
    set_en(1, 1);
    tick();
    chk("R6 tie to lower index", irq_vector, 8'h80);
    set_en(0, 0);
    tick();
    chk("R6 dev1 after dev0 disabled", irq_vector, 8'h81);

    // R4: ready without enable ignored; R5: higher level wins
    dev_ready[2] = 1;
    tick();
    chk("R4 disabled dev2 ignored", irq_vector, 8'h81);
    set_en(2, 1);
    tick();
    chk("R5 highest level wins", irq_vector, 8'h82);
    chk("R5 level six", irq_level, 6);

    // R7: equal level blocked, lower level passes
    cur_pl = 6;
    tick(); tick();
    chk("R7 equal level blocked", irq, 0);
    chk("R9 zero vector when idle", irq_vector, 0);
    cur_pl = 5;
    tick(); tick();
    chk("R7 strictly higher passes", irq, 1);

    // R8: hold without strobe
    fetch_bnd = 0; cur_pl = 7;
    tick(); tick();
    chk("R8 held without strobe", irq, 1);
    fetch_bnd = 1;
    tick(); tick();
    chk("R8 updates on strobe", irq, 0);

    // dev3 alone at level 1
    cur_pl = 0; dev_ready = 4'b1000;
    set_en(3, 1);
    tick();
    chk("R5 dev3 alone", irq_vector, 8'h83);
    chk("R9 dev3 level", irq_level, 1);

    // Random phase
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      cmp_model();
      dev_ready = 4'($urandom);
      wr_en     = ($urandom % 4) == 0;
      wr_sel    = 2'($urandom);
      wr_data   = 16'($urandom);
      rd_sel    = 2'($urandom);
      cur_pl    = 3'($urandom);
      fetch_bnd = ($urandom % 3) != 0;
      #1;
      chk("R3 rd_data same cycle", rd_data, {dev_ready[rd_sel], m_en[rd_sel], 14'b0});
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 async clear irq", irq, 0);
    chk("R1 async clear level", irq_level, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule